// File: doc/BRIEF.md
# Register Scoreboard Hazard Interlock

This block guards the decode stage of an in-order pipeline against operand hazards without any forwarding paths. It keeps one busy bit for every architectural register. The bit of a destination register is raised when an instruction that writes that register leaves decode. It is lowered when a write-back port reports that the write to that register has finished. While an instruction at decode names a busy register as a source, or as its destination, the block holds it back.

Decode offers an instruction with `dec_valid` and the block answers with `dec_ready`. A low `dec_ready` is the stall. The instruction issues on a cycle where both are high, and only then does its destination become busy. `dec_ready` depends only on the current busy bits and the register numbers offered, never on `dec_valid`. Decode must hold its fields stable while it waits.

Write-back ports are plain strobes with no back-pressure. Each port carries a valid bit and a register number, and the block always accepts them. A completion takes effect on the busy bit at the next clock edge. It does not release a stalled instruction in the same cycle. Register 0 can be declared permanently free, for register files where it is hardwired to zero.

Top module: `reg_interlock`

## Requirements
- R1: While `rst` is high and on the first cycle after it, every register reads as not busy. With no write-back activity, probing any register as a source gives `dec_ready` = 1.
- R2: An issue (`dec_valid` and `dec_ready` high, `dec_dst_use` = 1) makes register `dec_dst_idx` busy from the next cycle on.
- R3: `wb_valid[k]` = 1 clears the busy bit of the register in `wb_idx[k*IDX_W +: IDX_W]` from the next cycle on, and not in the same cycle. Several ports may clear different registers in one cycle.
- R4: `dec_ready` is 0 when any source slot s with `dec_src_use[s]` = 1 names a busy register. It is found in `dec_src_idx[s*IDX_W +: IDX_W]`. A slot whose use bit is 0 has no effect.
- R5: `dec_ready` is 0 when `dec_dst_use` = 1 and `dec_dst_idx` names a busy register (write-after-write interlock).
- R6: When an issue sets a register and a write-back clears that same register in the same cycle, the register is busy afterwards.
- R7: With `ZERO_FREE` = 1, register 0 is never busy. An instruction writing register 0 never stalls on it, and later readers of register 0 never stall.
- R8: No busy bit changes without an issue or a write-back. In particular, a stalled instruction, or one with `dec_valid` low, sets nothing.
- R9: `dec_ready` does not depend on `dec_valid`. It reports the stall even when `dec_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dec_valid | input | 1 | Decode offers an instruction |
| dec_ready | output | 1 | No hazard; low means stall |
| dec_src_idx | input | NSRC*IDX_W | Source register numbers, slot s at bits s*IDX_W |
| dec_src_use | input | NSRC | Per-slot flag: the source is read |
| dec_dst_idx | input | IDX_W | Destination register number |
| dec_dst_use | input | 1 | Instruction writes a register |
| wb_valid | input | NWB | Per-port write completion strobe |
| wb_idx | input | NWB*IDX_W | Completed register numbers, port k at bits k*IDX_W |

## Verification
An issue's set and a write-back's clear can land in the same cycle. When they hit one register, the set must win. When they hit different registers, both must take effect. The bench provokes this by issuing an instruction whose destination is being reported complete on a write-back port in that same cycle. It then probes that register as a source on the next cycle and expects a stall. A clear also coincides with decode reading the register it frees. That case is judged by a stall in the clearing cycle and a release one cycle later.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
  localparam int unsigned RSB_DEF_REGS = 32;
  localparam int unsigned RSB_DEF_SRCS = 2;
  localparam int unsigned RSB_DEF_WBS  = 2;

  // One slot of a flat register-number vector
  function automatic int unsigned slot_lsb(input int unsigned slot, input int unsigned w);
    return slot * w;
  endfunction
endpackage

// File: rtl/rsb_wb_decode.sv
module rsb_wb_decode #(
  parameter int unsigned NREGS = 32,
  parameter int unsigned NWB   = 2,
  parameter int unsigned IDX_W = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NWB-1:0]       wb_valid,
  input  logic [NWB*IDX_W-1:0] wb_idx,
  output logic [NREGS-1:0]     clr_mask
);
  always_comb begin
    clr_mask = '0;
    for (int k = 0; k < NWB; k++) begin
      for (int r = 0; r < NREGS; r++) begin
        if (wb_valid[k] && wb_idx[rsb_pkg::slot_lsb(k, IDX_W) +: IDX_W] == IDX_W'(r))
          clr_mask[r] = 1'b1;
      end
    end
  end

  AST_CLR_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    $countones(clr_mask) <= $countones(wb_valid)); // R3
endmodule

// File: rtl/rsb_busy_table.sv
module rsb_busy_table #(
  parameter int unsigned NREGS     = 32,
  parameter bit          ZERO_FREE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NREGS-1:0] set_mask,
  input  logic [NREGS-1:0] clr_mask,
  output logic [NREGS-1:0] busy
);
  for (genvar r = 0; r < NREGS; r++) begin : g_tag
    if (ZERO_FREE && r == 0) begin : g_fixed
      logic unused_zero;
      assign unused_zero = set_mask[r] ^ clr_mask[r];
      assign busy[r] = 1'b0;
    end else begin : g_bit
      logic q;
      always_ff @(posedge clk) begin
        if (rst)              q <= 1'b0;
        else if (set_mask[r]) q <= 1'b1;
        else if (clr_mask[r]) q <= 1'b0;
      end
      assign busy[r] = q;

      AST_WB_CLEARS: assert property (@(posedge clk) disable iff (rst)
        clr_mask[r] && !set_mask[r] |=> !busy[r]); // R3
      AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        set_mask[r] && clr_mask[r] |=> busy[r]); // R6
      AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !set_mask[r] && !clr_mask[r] |=> $stable(busy[r])); // R8
    end
  end
endmodule

// File: rtl/rsb_hazard_check.sv
module rsb_hazard_check #(
  parameter int unsigned NREGS = 32,
  parameter int unsigned NSRC  = 2,
  parameter int unsigned IDX_W = 5
) (
  input  logic [NREGS-1:0]      busy,
  input  logic [NSRC*IDX_W-1:0] src_idx,
  input  logic [NSRC-1:0]       src_use,
  input  logic [IDX_W-1:0]      dst_idx,
  input  logic                  dst_use,
  output logic [NSRC-1:0]       src_hit,
  output logic                  dst_hit,
  output logic                  clear_to_go
);
  always_comb begin
    src_hit = '0;
    for (int s = 0; s < NSRC; s++) begin
      for (int r = 0; r < NREGS; r++) begin
        if (src_use[s] && busy[r] &&
            src_idx[rsb_pkg::slot_lsb(s, IDX_W) +: IDX_W] == IDX_W'(r))
          src_hit[s] = 1'b1;
      end
    end
  end

  always_comb begin
    dst_hit = 1'b0;
    for (int r = 0; r < NREGS; r++) begin
      if (dst_use && busy[r] && dst_idx == IDX_W'(r))
        dst_hit = 1'b1;
    end
  end

  assign clear_to_go = ~(|src_hit) & ~dst_hit;
endmodule

// File: rtl/reg_interlock.sv
module reg_interlock #(
  parameter int unsigned NREGS     = rsb_pkg::RSB_DEF_REGS,
  parameter int unsigned NSRC      = rsb_pkg::RSB_DEF_SRCS,
  parameter int unsigned NWB       = rsb_pkg::RSB_DEF_WBS,
  parameter bit          ZERO_FREE = 1'b1,
  localparam int unsigned IDX_W    = $clog2(NREGS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  dec_valid,
  output logic                  dec_ready,
  input  logic [NSRC*IDX_W-1:0] dec_src_idx,
  input  logic [NSRC-1:0]       dec_src_use,
  input  logic [IDX_W-1:0]      dec_dst_idx,
  input  logic                  dec_dst_use,
  input  logic [NWB-1:0]        wb_valid,
  input  logic [NWB*IDX_W-1:0]  wb_idx
);
  logic [NREGS-1:0] busy;
  logic [NREGS-1:0] set_mask;
  logic [NREGS-1:0] clr_mask;
  logic [NSRC-1:0]  src_hit;
  logic             dst_hit;
  logic             go;
  logic             fire;

  rsb_wb_decode #(.NREGS(NREGS), .NWB(NWB), .IDX_W(IDX_W)) u_wb (
    .clk(clk), .rst(rst), .wb_valid(wb_valid), .wb_idx(wb_idx), .clr_mask(clr_mask)
  );

  rsb_hazard_check #(.NREGS(NREGS), .NSRC(NSRC), .IDX_W(IDX_W)) u_hz (
    .busy(busy), .src_idx(dec_src_idx), .src_use(dec_src_use),
    .dst_idx(dec_dst_idx), .dst_use(dec_dst_use),
    .src_hit(src_hit), .dst_hit(dst_hit), .clear_to_go(go)
  );

  rsb_busy_table #(.NREGS(NREGS), .ZERO_FREE(ZERO_FREE)) u_tab (
    .clk(clk), .rst(rst), .set_mask(set_mask), .clr_mask(clr_mask), .busy(busy)
  );

  assign dec_ready = go;
  assign fire      = dec_valid & go & dec_dst_use;

  always_comb begin
    set_mask = '0;
    for (int r = 0; r < NREGS; r++) begin
      if (fire && dec_dst_idx == IDX_W'(r))
        set_mask[r] = 1'b1;
    end
    if (ZERO_FREE)
      set_mask[0] = 1'b0;
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_src_chk
    AST_SRC_INTERLOCK: assert property (@(posedge clk) disable iff (rst)
      dec_src_use[s] && busy[dec_src_idx[s*IDX_W +: IDX_W]] |-> !dec_ready); // R4
  end

  AST_DST_INTERLOCK: assert property (@(posedge clk) disable iff (rst)
    dec_dst_use && busy[dec_dst_idx] |-> !dec_ready); // R5

  AST_ISSUE_SETS: assert property (@(posedge clk) disable iff (rst)
    dec_valid && dec_ready && dec_dst_use && !(ZERO_FREE && dec_dst_idx == '0)
    |=> busy[$past(dec_dst_idx)]); // R2

  AST_ZERO_FREE: assert property (@(posedge clk) disable iff (rst)
    ZERO_FREE && dec_dst_use && dec_dst_idx == '0 && dec_src_use == '0 |-> dec_ready); // R7

  AST_ONE_SET: assert property (@(posedge clk) disable iff (rst)
    $onehot0(set_mask)); // R2
endmodule

// File: tb/sim_reg_interlock.sv
`timescale 1ns/100ps
module sim_reg_interlock;
  localparam int NR = 32;
  localparam int IW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          dec_valid = 1'b0;
  logic          dec_ready;
  logic [2*IW-1:0] dec_src_idx = '0;
  logic [1:0]    dec_src_use = '0;
  logic [IW-1:0] dec_dst_idx = '0;
  logic          dec_dst_use = 1'b0;
  logic [1:0]    wb_valid = '0;
  logic [2*IW-1:0] wb_idx = '0;

  always #2 clk = ~clk;

  reg_interlock #(.NREGS(NR), .NSRC(2), .NWB(2), .ZERO_FREE(1'b1)) u0 (
    .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_ready(dec_ready),
    .dec_src_idx(dec_src_idx), .dec_src_use(dec_src_use),
    .dec_dst_idx(dec_dst_idx), .dec_dst_use(dec_dst_use),
    .wb_valid(wb_valid), .wb_idx(wb_idx)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;
  bit    model [NR];
  bit    exp_q [$];
  string tag_q [$];

  // Driver: applies one cycle of stimulus, predicts dec_ready, advances the model
  task automatic step(input bit v, input int s0, input bit u0s, input int s1, input bit u1s,
                      input int d, input bit du, input bit w0, input int wi0,
                      input bit w1, input int wi1, input string tag);
    bit e;
    @(posedge clk); #0.5;
    dec_valid   = v;
    dec_src_idx = {IW'(s1), IW'(s0)};
    dec_src_use = {u1s, u0s};
    dec_dst_idx = IW'(d);
    dec_dst_use = du;
    wb_valid    = {w1, w0};
    wb_idx      = {IW'(wi1), IW'(wi0)};
    e = !((u0s && model[s0]) || (u1s && model[s1]) || (du && model[d]));
    exp_q.push_back(e);
    tag_q.push_back(tag);
    if (w0) model[wi0] = 1'b0;
    if (w1) model[wi1] = 1'b0;
    if (v && e && du && d != 0) model[d] = 1'b1;
  endtask

  task automatic probe(input int r, input string tag);
    step(1'b1, r, 1'b1, 0, 1'b0, 0, 1'b0, 1'b0, 0, 1'b0, 0, tag);
  endtask

  task automatic issue(input int d, input string tag);
    step(1'b1, 0, 1'b0, 0, 1'b0, d, 1'b1, 1'b0, 0, 1'b0, 0, tag);
  endtask

  // Monitor: compares each predicted item with the port, mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        bit    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_vec++;
        if (dec_ready !== e) begin
          n_bad++;
          $display("FAIL %s: dec_ready=%0b expected %0b", t, dec_ready, e);
        end
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < NR; r++) model[r] = 1'b0;
    repeat (3) @(posedge clk);
    #0.5 rst = 1'b0;

    // R1: all registers free after reset
    for (int r = 0; r < NR; r++) probe(r, "R1 reset clears tag");

    // R2 / R4: issue to 5, then readers of 5 stall
    issue(5, "R2 issue dst5");
    probe(5, "R4 src0 reads busy r5");
    step(1'b1, 0, 1'b0, 5, 1'b1, 0, 1'b0, 1'b0, 0, 1'b0, 0, "R4 src1 reads busy r5");
    step(1'b1, 5, 1'b0, 6, 1'b1, 0, 1'b0, 1'b0, 0, 1'b0, 0, "R4 unused slot ignored");

    // R8: stalled instruction does not claim its destination
    step(1'b1, 5, 1'b1, 0, 1'b0, 7, 1'b1, 1'b0, 0, 1'b0, 0, "R8 stalled issue");
    probe(7, "R8 stalled dst7 stays free");
    step(1'b0, 0, 1'b0, 0, 1'b0, 8, 1'b1, 1'b0, 0, 1'b0, 0, "R8 valid low");
    probe(8, "R8 valid low left r8 free");

    // R5: write-after-write interlock
    issue(5, "R5 dst busy stalls");

    // R3: clear takes effect next cycle
    step(1'b1, 5, 1'b1, 0, 1'b0, 0, 1'b0, 1'b1, 5, 1'b0, 0, "R3 clear not same cycle");
    probe(5, "R3 r5 released");
    issue(10, "R2 issue dst10");
    issue(11, "R2 issue dst11");
    step(1'b1, 10, 1'b1, 11, 1'b1, 0, 1'b0, 1'b1, 10, 1'b1, 11, "R3 two ports before clear");
    step(1'b1, 10, 1'b1, 11, 1'b1, 0, 1'b0, 1'b0, 0, 1'b0, 0, "R3 two ports cleared");

    // R6: set and clear of the same register in one cycle
    step(1'b1, 0, 1'b0, 0, 1'b0, 9, 1'b1, 1'b1, 9, 1'b0, 0, "R6 set with clear");
    probe(9, "R6 set wins");

    // R9: ready independent of valid
    step(1'b0, 9, 1'b1, 0, 1'b0, 0, 1'b0, 1'b0, 0, 1'b0, 0, "R9 stall with valid low");
    step(1'b0, 3, 1'b1, 0, 1'b0, 0, 1'b0, 1'b1, 9, 1'b0, 0, "R9 ready with valid low");
    probe(9, "R3 r9 released");

    // R7: register 0 never busy
    issue(0, "R7 write r0");
    issue(0, "R7 write r0 again");
    probe(0, "R7 read r0");

    // Mixed traffic
    for (int i = 0; i < 600; i++) begin
      int unsigned a, b, c, d, w, x;
      a = $urandom_range(NR - 1);
      b = $urandom_range(NR - 1);
      c = $urandom_range(NR - 1);
      d = $urandom_range(NR - 1);
      w = $urandom_range(NR - 1);
      x = $urandom_range(NR - 1);
      step($urandom_range(3) != 0, a, $urandom_range(1) == 1, b, $urandom_range(1) == 1,
           c, $urandom_range(3) != 0, $urandom_range(1) == 1, w, $urandom_range(2) == 0, x,
           "R2 R3 R4 R5 mixed traffic");
      if (d == 0) probe(c, "R2 mixed probe");
    end

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule